// File: doc/BRIEF.md
# Frame-buffer scanout controller

This block turns a packed frame buffer in video memory into a raster video stream. Two axis counters walk a frame made of active, front-porch, sync and back-porch intervals, each sized by a parameter. For every pixel position the block forms a byte address from the two counters and the display-buffer configuration. It presents that address to a memory that answers combinationally in the same cycle. It then splits the returned 32-bit word into 8-bit red, green and blue. Along with the colour it drives horizontal sync, vertical sync and data-enable.

Three 64-bit configuration values come in as plain inputs and are used as they stand in every cycle. The mode value holds the output enable. The display-buffer value holds the page base, the row stride and the pixel format. The window value defines a rectangle of the active area where colour is shown. The memory read has no handshake: the address is combinational from the counters and the buffer value, and the data must be valid in the same cycle. There is therefore no back-pressure, and the raster never stalls. Once per frame the block pulses a frame-end strobe, and one cycle later it pulses a frame event.

Top module: `fb_scanout`

## Requirements
- R1: Reset puts both counters at zero. The horizontal counter runs 0 to H_ACT+H_FP+H_SYNC+H_BP-1 and then wraps, and the vertical counter advances on each horizontal wrap. `de` is high exactly when horizontal < H_ACT and vertical < V_ACT, and red, green and blue are zero whenever `de` is low.
- R2: `hsync` is high, active high, while the horizontal count lies in [H_ACT+H_FP, H_ACT+H_FP+H_SYNC). `vsync` is high while the vertical count lies in [V_ACT+V_FP, V_ACT+V_FP+V_SYNC). Neither is ever high while `de` is high.
- R3: While `de` is high, `mem_addr` = base*8192 + (v*stride*64 + h)*4. Here base is display-buffer bits [8:0] and stride (the row width in 64-pixel units) is bits [14:9].
- R4: Mode bit 0 enables output. While it is 0, red, green and blue are zero. A change takes effect on the pixel presented in the cycle the new value is applied.
- R5: For a shown pixel, red = `mem_data[7:0]`, green = `mem_data[15:8]` and blue = `mem_data[23:16]`. Bits [31:24] are ignored.
- R6: The window value holds X offset in bits [11:0], Y offset in bits [22:12], width-1 in bits [43:32] and height-1 in bits [54:44]. An active pixel with h outside [X, X+width-1] or v outside [Y, Y+height-1] shows zero colour.
- R7: The pixel format is display-buffer bits [19:15]. Only format 0 (32 bits per pixel) shows colour, and any other value gives zero colour.
- R8: `frame_end` is high for exactly the last cycle of each frame (both counters at their maximum). `frame_evt` is high in the cycle after each `frame_end` and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_reg | input | 64 | Mode value; bit 0 enables output |
| dispbuf_reg | input | 64 | Display buffer: base [8:0], stride [14:9], format [19:15] |
| window_reg | input | 64 | Display window: X [11:0], Y [22:12], width-1 [43:32], height-1 [54:44] |
| mem_addr | output | AW | Byte address of the current pixel |
| mem_data | input | 32 | Word read at `mem_addr`, valid in the same cycle |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, high in the active area |
| red | output | 8 | Red component |
| green | output | 8 | Green component |
| blue | output | 8 | Blue component |
| frame_end | output | 1 | One-cycle strobe in the last cycle of a frame |
| frame_evt | output | 1 | One-cycle frame event, the cycle after `frame_end` |

## Verification
The hardest condition to reach from the ports is a change in the enable or the configuration partway through a line. Such a change must act on exactly the pixel being presented, with nothing held over from earlier settings. The bench flips the enable every seven cycles, so the toggles drift across line and frame boundaries. It compares every cycle against an arithmetic model. It also sweeps a window that reaches past the active area and a nonzero page base with stride 2. The memory model returns a word derived from the address, so any address error also shows up as a colour mismatch.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

  localparam int PAGE_SHIFT   = 13;
  localparam int STRIDE_SHIFT = 6;
  localparam int BYTE_SHIFT   = 2;
  localparam logic [4:0] FMT_RGBA32 = 5'd0;

  typedef struct packed {
    logic [8:0] base;
    logic [5:0] stride;
    logic [4:0] fmt;
  } fbuf_cfg_t;

  typedef struct packed {
    logic [11:0] x0;
    logic [10:0] y0;
    logic [11:0] wm1;
    logic [10:0] hm1;
  } win_cfg_t;

  function automatic fbuf_cfg_t decode_fbuf(input logic [19:0] r);
    fbuf_cfg_t c;
    c.base   = r[8:0];
    c.stride = r[14:9];
    c.fmt    = r[19:15];
    return c;
  endfunction

  function automatic win_cfg_t decode_win(input logic [22:0] lo, input logic [22:0] hi);
    win_cfg_t w;
    w.x0  = lo[11:0];
    w.y0  = lo[22:12];
    w.wm1 = hi[11:0];
    w.hm1 = hi[22:12];
    return w;
  endfunction

endpackage

// File: rtl/fb_axis_counter.sv
module fb_axis_counter #(
  parameter int ACT  = 16,
  parameter int FP   = 1,
  parameter int SYNC = 1,
  parameter int BP   = 1,
  localparam int TOTAL = ACT + FP + SYNC + BP,
  localparam int CW    = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          in_act,
  output logic          in_sync,
  output logic          at_last
);

  localparam int SYNC_START = ACT + FP;
  localparam int SYNC_STOP  = ACT + FP + SYNC;

  assign at_last = (32'(cnt) == TOTAL - 1);
  assign in_act  = (32'(cnt) < ACT);
  assign in_sync = (32'(cnt) >= SYNC_START) && (32'(cnt) < SYNC_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
  import fb_scan_pkg::*;
#(
  parameter int HCW = 5,
  parameter int VCW = 4,
  parameter int AW  = 32
) (
  input  logic [HCW-1:0] hcnt,
  input  logic [VCW-1:0] vcnt,
  input  logic [8:0]     base,
  input  logic [5:0]     stride,
  output logic [AW-1:0]  addr
);

  logic [AW-1:0] row_units;
  logic [AW-1:0] pix_index;
  logic [AW-1:0] page_off;

  always_comb begin
    row_units = AW'(vcnt) * AW'(stride);
    pix_index = (row_units << STRIDE_SHIFT) + AW'(hcnt);
    page_off  = AW'(base) << PAGE_SHIFT;
    addr      = page_off + (pix_index << BYTE_SHIFT);
  end

endmodule

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack
  import fb_scan_pkg::*;
#(
  parameter int HCW = 5,
  parameter int VCW = 4
) (
  input  logic [HCW-1:0] hcnt,
  input  logic [VCW-1:0] vcnt,
  input  logic           active,
  input  logic           enable,
  input  logic [4:0]     fmt,
  input  win_cfg_t       win,
  input  logic [23:0]    word,
  output logic [7:0]     red,
  output logic [7:0]     green,
  output logic [7:0]     blue
);

  logic [12:0] h_ext, x_end;
  logic [11:0] v_ext, y_end;
  logic        in_win, show;

  always_comb begin
    h_ext  = 13'(hcnt);
    v_ext  = 12'(vcnt);
    x_end  = 13'(win.x0) + 13'(win.wm1);
    y_end  = 12'(win.y0) + 12'(win.hm1);
    in_win = (h_ext >= 13'(win.x0)) && (h_ext <= x_end) &&
             (v_ext >= 12'(win.y0)) && (v_ext <= y_end);
    show   = enable && active && in_win && (fmt == FMT_RGBA32);
    red    = show ? word[7:0]   : 8'd0;
    green  = show ? word[15:8]  : 8'd0;
    blue   = show ? word[23:16] : 8'd0;
  end

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import fb_scan_pkg::*;
#(
  parameter int H_ACT  = 16,
  parameter int H_FP   = 1,
  parameter int H_SYNC = 1,
  parameter int H_BP   = 1,
  parameter int V_ACT  = 8,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 1,
  parameter int V_BP   = 1,
  parameter int AW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   mode_reg,
  input  logic [63:0]   dispbuf_reg,
  input  logic [63:0]   window_reg,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [7:0]    red,
  output logic [7:0]    green,
  output logic [7:0]    blue,
  output logic          frame_end,
  output logic          frame_evt
);

  localparam int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HCW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1;
  localparam int VCW = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1;

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic h_act, h_sync, h_last;
  logic v_act, v_sync, v_last;
  fbuf_cfg_t fbuf;
  win_cfg_t  win;
  logic unused_bits;

  assign fbuf = decode_fbuf(dispbuf_reg[19:0]);
  assign win  = decode_win(window_reg[22:0], window_reg[54:32]);
  assign unused_bits = ^{mode_reg[63:1], dispbuf_reg[63:20],
                         window_reg[31:23], window_reg[63:55], mem_data[31:24]};

  fb_axis_counter #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_hax (
    .clk(clk), .rst_n(rst_n), .step(1'b1),
    .cnt(hcnt), .in_act(h_act), .in_sync(h_sync), .at_last(h_last)
  );

  fb_axis_counter #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_vax (
    .clk(clk), .rst_n(rst_n), .step(h_last),
    .cnt(vcnt), .in_act(v_act), .in_sync(v_sync), .at_last(v_last)
  );

  fb_addr_gen #(.HCW(HCW), .VCW(VCW), .AW(AW)) u_addr (
    .hcnt(hcnt), .vcnt(vcnt), .base(fbuf.base), .stride(fbuf.stride),
    .addr(mem_addr)
  );

  fb_pixel_unpack #(.HCW(HCW), .VCW(VCW)) u_unpack (
    .hcnt(hcnt), .vcnt(vcnt), .active(de), .enable(mode_reg[0]),
    .fmt(fbuf.fmt), .win(win), .word(mem_data[23:0]),
    .red(red), .green(green), .blue(blue)
  );

  assign de        = h_act && v_act;
  assign hsync     = h_sync;
  assign vsync     = v_sync;
  assign frame_end = h_last && v_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_evt <= 1'b0;
    end else begin
      frame_evt <= frame_end;
    end
  end

endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_en,
  input logic [4:0] fmt_bits,
  input logic       de,
  input logic       hsync,
  input logic       vsync,
  input logic [7:0] red,
  input logic [7:0] green,
  input logic [7:0] blue,
  input logic       frame_end,
  input logic       frame_evt
);

  p_blank_black_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> ({red, green, blue} == 24'd0));

  p_sync_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |-> !de);

  p_off_black_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> ({red, green, blue} == 24'd0));

  p_fmt_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_bits != 5'd0) |-> ({red, green, blue} == 24'd0));

  p_eof_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  p_evt_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> frame_evt);

  p_evt_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |-> $past(frame_end));

endmodule

bind fb_scanout fb_scanout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_reg[0]), .fmt_bits(dispbuf_reg[19:15]),
  .de(de), .hsync(hsync), .vsync(vsync), .red(red), .green(green), .blue(blue),
  .frame_end(frame_end), .frame_evt(frame_evt)
);

// File: tb/fb_scanout_bench.sv
`timescale 1ns/1ps
module fb_scanout_bench;

  localparam int HA = 16, HF = 1, HS = 1, HB = 1;
  localparam int VA = 8,  VF = 1, VS = 1, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] mode_reg = 64'd0;
  logic [63:0] dispbuf_reg = 64'd0;
  logic [63:0] window_reg = 64'd0;
  logic [31:0] mem_addr, mem_data;
  logic        hsync, vsync, de, frame_end, frame_evt;
  logic [7:0]  red, green, blue;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [7:0] r, g, b;
    r = a[9:2];
    g = a[17:10] ^ 8'h5A;
    b = a[9:2] ^ a[17:10] ^ 8'hC3;
    return {8'hEE, b, g, r};
  endfunction

  assign mem_data = mem_word(mem_addr);

  fb_scanout u_fb_scanout (
    .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .dispbuf_reg(dispbuf_reg),
    .window_reg(window_reg), .mem_addr(mem_addr), .mem_data(mem_data),
    .hsync(hsync), .vsync(vsync), .de(de), .red(red), .green(green), .blue(blue),
    .frame_end(frame_end), .frame_evt(frame_evt)
  );

  int total = 0;
  int bad = 0;
  int bh = 0;
  int bv = 0;
  bit prev_eof = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      bh <= 0; bv <= 0;
    end else if (bh == HT - 1) begin
      bh <= 0;
      bv <= (bv == VT - 1) ? 0 : bv + 1;
    end else begin
      bh <= bh + 1;
    end
  end

  function automatic logic [63:0] fbuf_val(input int base, input int stride, input int fmt);
    return {44'd0, 5'(fmt), 6'(stride), 9'(base)};
  endfunction

  function automatic logic [63:0] win_val(input int x0, input int y0, input int wm1, input int hm1);
    return {9'd0, 11'(hm1), 12'(wm1), 9'd0, 11'(y0), 12'(x0)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at h=%0d v=%0d: actual=0x%0h expected=0x%0h",
               req, what, bh, bv, act, exp);
    end
  endtask

  task automatic check_cycle();
    bit e_de, e_hs, e_vs, e_eof, show;
    int base, stride, fmt, x0, y0, wm1, hm1;
    logic [31:0] e_addr, w;
    logic [23:0] e_rgb;
    base = int'(dispbuf_reg[8:0]);
    stride = int'(dispbuf_reg[14:9]);
    fmt = int'(dispbuf_reg[19:15]);
    x0 = int'(window_reg[11:0]);
    y0 = int'(window_reg[22:12]);
    wm1 = int'(window_reg[43:32]);
    hm1 = int'(window_reg[54:44]);
    e_de = (bh < HA) && (bv < VA);
    e_hs = (bh >= HA + HF) && (bh < HA + HF + HS);
    e_vs = (bv >= VA + VF) && (bv < VA + VF + VS);
    e_eof = (bh == HT - 1) && (bv == VT - 1);
    e_addr = 32'(base * 8192 + (bv * stride * 64 + bh) * 4);
    show = mode_reg[0] && e_de && (fmt == 0) &&
           (bh >= x0) && (bh <= x0 + wm1) && (bv >= y0) && (bv <= y0 + hm1);
    w = mem_word(e_addr);
    e_rgb = show ? {w[7:0], w[15:8], w[23:16]} : 24'd0;
    chk(de == e_de, "R1", "de", de, e_de);
    chk(hsync == e_hs, "R2", "hsync", hsync, e_hs);
    chk(vsync == e_vs, "R2", "vsync", vsync, e_vs);
    chk(frame_end == e_eof, "R8", "frame_end", frame_end, e_eof);
    chk(frame_evt == prev_eof, "R8", "frame_evt", frame_evt, prev_eof);
    if (e_de) chk(mem_addr == e_addr, "R3", "mem_addr", mem_addr, e_addr);
    if (!mode_reg[0]) chk({red, green, blue} == 24'd0, "R4", "rgb while disabled", {red, green, blue}, 0);
    else if (fmt != 0) chk({red, green, blue} == 24'd0, "R7", "rgb bad format", {red, green, blue}, 0);
    else if (e_de && !show) chk({red, green, blue} == 24'd0, "R6", "rgb outside window", {red, green, blue}, 0);
    else chk({red, green, blue} == e_rgb, "R5", "rgb", {red, green, blue}, e_rgb);
    prev_eof = e_eof;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      check_cycle();
    end
  endtask

  initial begin
    dispbuf_reg = fbuf_val(0, 1, 0);
    window_reg = win_val(0, 0, HA - 1, VA - 1);
    // R1: reset state, counters held at zero
    run(3);
    rst_n = 1'b1;
    // R4: output disabled for a full frame
    run(FRAME);
    // R5 R3: enabled, full window, base 0, stride 1
    mode_reg = 64'd1;
    run(2 * FRAME);
    // R3 R6: nonzero base, stride 2, inner window
    dispbuf_reg = fbuf_val(3, 2, 0);
    window_reg = win_val(2, 1, 5, 3);
    run(FRAME);
    // R6: window reaching past the active area
    window_reg = win_val(10, 6, 20, 5);
    run(FRAME);
    // R7: non-32-bit format gives black
    dispbuf_reg = fbuf_val(1, 1, 1);
    window_reg = win_val(0, 0, HA - 1, VA - 1);
    run(FRAME);
    // R4: enable toggled mid-line
    dispbuf_reg = fbuf_val(0, 1, 0);
    for (int k = 0; k < (2 * FRAME) / 7; k++) begin
      mode_reg[0] = ~mode_reg[0];
      run(7);
    end
    // R5: upper data byte ignored, different stride
    mode_reg = 64'd1;
    dispbuf_reg = fbuf_val(5, 3, 0);
    run(FRAME);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule